// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller for a parameterised number of pins (16 by default). It sits behind a simple strobed register bus. Software programs each pin as an input or an output. It drives output values through a data latch, which can be written whole or changed bit by bit. It reads pin states after a two-flop synchronizer.

Each pin can raise an interrupt. A pin can be level-sensitive with a chosen polarity. It can also be edge-sensitive, with separate enables for rising and falling edges, and both edges may be enabled together. A pending interrupt only reaches software if the pin is unmasked and enabled. All qualified pending bits are ORed into one registered interrupt line.

The bus width equals the pin count. Register offsets are byte addresses on an 8-bit address. Read data is registered and appears the cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the mask register (0x28) reads all ones, and the enable (0x2C), direction (0x00) and output data (0x20) registers read zero. The irq output is low.
- R2: The direction register at 0x00 drives pin_oe. A bit of 1 makes that pin an output; a bit of 0 makes it an input. A write is visible on pin_oe the cycle after the write strobe.
- R3: The output data register at 0x20 is read/write. Reading it returns the output latch. pin_out always presents the latch.
- R4: A write to 0x18 sets every latch bit whose write-data bit is 1. A write to 0x1C clears every latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Reading 0x14 returns the pin inputs after two synchronizing flops, for every pin whatever its direction.
- R6: When a pin's level-select bit (0x04) is 1, its pending bit follows the synchronized input compared against its polarity bit (0x08): 1 means active high, 0 means active low. A clear write has no effect while the level stays active.
- R7: When a pin's level-select bit is 0, a rising edge sets pending if its rising enable bit (0x0C) is 1. A falling edge sets pending if its falling enable bit (0x10) is 1. The two enables are independent. A pending bit set by an edge stays set until cleared. An edge whose enable is 0 sets nothing.
- R8: Writing 1s to 0x34 clears those edge-pending bits. An edge arriving in the same cycle as the clear leaves the bit set.
- R9: The status register at 0x30 returns the pending bits whose mask bit (0x28) is 0 and whose enable bit (0x2C) is 1. Pending bits keep latching while gated, and appear in the status once the gating opens.
- R10: irq is high one cycle after any status bit is set, and low one cycle after all status bits are clear.
- R11: bus_rdata updates the cycle after bus_rd is sampled high and holds otherwise. Unmapped offsets and the write-only offsets 0x18, 0x1C and 0x34 read zero. Writes to 0x14 and 0x30 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NPINS (16) | Write data |
| bus_rdata | output | NPINS (16) | Registered read data |
| pin_in | input | NPINS (16) | Asynchronous pin inputs |
| pin_out | output | NPINS (16) | Output latch |
| pin_oe | output | NPINS (16) | Output enable per pin (direction) |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Each result has a fixed delay from its stimulus, and every check samples at that delay.

- A register write is visible on pin_oe, pin_out and in read-back one cycle after the write strobe.
- A pin change reaches the synchronized value two cycles after it is driven.
- An edge or level reaches pending one cycle after that, and irq one cycle after pending.
- Read data lands the cycle after the read strobe.

A behavioural model advances by the same delays and is compared on the falling edge of every cycle. The directed checks wait at least four cycles after each pin change before reading. The clear-collision case places the clear write exactly in the cycle where the synchronized edge is evaluated.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] OFS_DIR   = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_LSEL  = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_LPOL  = 8'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_RISE  = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_FALL  = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_DIN   = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_OSET  = 8'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_OCLR  = 8'h1C;
    localparam logic [REG_ADDR_W-1:0] OFS_ODATA = 8'h20;
    localparam logic [REG_ADDR_W-1:0] OFS_MASK  = 8'h28;
    localparam logic [REG_ADDR_W-1:0] OFS_IEN   = 8'h2C;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT  = 8'h30;
    localparam logic [REG_ADDR_W-1:0] OFS_ICLR  = 8'h34;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_LSEL,
        SEL_LPOL,
        SEL_RISE,
        SEL_FALL,
        SEL_DIN,
        SEL_OSET,
        SEL_OCLR,
        SEL_ODATA,
        SEL_MASK,
        SEL_IEN,
        SEL_STAT,
        SEL_ICLR
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_DIR:   s = SEL_DIR;
            OFS_LSEL:  s = SEL_LSEL;
            OFS_LPOL:  s = SEL_LPOL;
            OFS_RISE:  s = SEL_RISE;
            OFS_FALL:  s = SEL_FALL;
            OFS_DIN:   s = SEL_DIN;
            OFS_OSET:  s = SEL_OSET;
            OFS_OCLR:  s = SEL_OCLR;
            OFS_ODATA: s = SEL_ODATA;
            OFS_MASK:  s = SEL_MASK;
            OFS_IEN:   s = SEL_IEN;
            OFS_STAT:  s = SEL_STAT;
            OFS_ICLR:  s = SEL_ICLR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);

    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_i,
    input  logic [NPINS-1:0] rise_i,
    input  logic [NPINS-1:0] fall_i,
    input  logic [NPINS-1:0] lsel_i,
    input  logic [NPINS-1:0] lpol_i,
    input  logic [NPINS-1:0] rise_en_i,
    input  logic [NPINS-1:0] fall_en_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic pend_d, pend_q;
        logic edge_hit, level_hit;

        always_comb begin
            edge_hit  = (rise_i[i] & rise_en_i[i]) | (fall_i[i] & fall_en_i[i]);
            level_hit = (sync_i[i] == lpol_i[i]);
            if (lsel_i[i]) begin
                pend_d = level_hit;
            end else begin
                pend_d = edge_hit | (pend_q & ~clr_i[i]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= pend_d;
            end
        end

        assign pend_o[i] = pend_q;
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    input  logic [NPINS-1:0]  din_i,
    input  logic [NPINS-1:0]  status_i,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  lsel_o,
    output logic [NPINS-1:0]  lpol_o,
    output logic [NPINS-1:0]  rise_en_o,
    output logic [NPINS-1:0]  fall_en_o,
    output logic [NPINS-1:0]  outv_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  ien_o,
    output logic [NPINS-1:0]  clr_o
);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] lsel;
        logic [NPINS-1:0] lpol;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] outv;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] rdata;
    } regs_t;

    regs_t    rg_d, rg_q;
    reg_sel_e sel;

    always_comb begin
        rg_d = rg_q;
        sel  = decode_ofs(addr_i);

        if (wr_i) begin
            case (sel)
                SEL_DIR:   rg_d.dir  = wdata_i;
                SEL_LSEL:  rg_d.lsel = wdata_i;
                SEL_LPOL:  rg_d.lpol = wdata_i;
                SEL_RISE:  rg_d.rise = wdata_i;
                SEL_FALL:  rg_d.fall = wdata_i;
                SEL_OSET:  rg_d.outv = rg_q.outv | wdata_i;
                SEL_OCLR:  rg_d.outv = rg_q.outv & ~wdata_i;
                SEL_ODATA: rg_d.outv = wdata_i;
                SEL_MASK:  rg_d.mask = wdata_i;
                SEL_IEN:   rg_d.ien  = wdata_i;
                default:   ;
            endcase
        end

        if (rd_i) begin
            case (sel)
                SEL_DIR:   rg_d.rdata = rg_q.dir;
                SEL_LSEL:  rg_d.rdata = rg_q.lsel;
                SEL_LPOL:  rg_d.rdata = rg_q.lpol;
                SEL_RISE:  rg_d.rdata = rg_q.rise;
                SEL_FALL:  rg_d.rdata = rg_q.fall;
                SEL_DIN:   rg_d.rdata = din_i;
                SEL_ODATA: rg_d.rdata = rg_q.outv;
                SEL_MASK:  rg_d.rdata = rg_q.mask;
                SEL_IEN:   rg_d.rdata = rg_q.ien;
                SEL_STAT:  rg_d.rdata = status_i;
                default:   rg_d.rdata = '0;
            endcase
        end

        clr_o = (wr_i && sel == SEL_ICLR) ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.mask <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign dir_o     = rg_q.dir;
    assign lsel_o    = rg_q.lsel;
    assign lpol_o    = rg_q.lpol;
    assign rise_en_o = rg_q.rise;
    assign fall_en_o = rg_q.fall;
    assign outv_o    = rg_q.outv;
    assign mask_o    = rg_q.mask;
    assign ien_o     = rg_q.ien;
    assign rdata_o   = rg_q.rdata;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = gpio_irq_pkg::REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0] sync_w, rise_w, fall_w;
    logic [NPINS-1:0] dir_w, lsel_w, lpol_w, rise_en_w, fall_en_w;
    logic [NPINS-1:0] outv_w, mask_w, ien_w, clr_w;
    logic [NPINS-1:0] pend_w, status_w;
    logic             irq_d, irq_q;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .din_i     (sync_w),
        .status_i  (status_w),
        .dir_o     (dir_w),
        .lsel_o    (lsel_w),
        .lpol_o    (lpol_w),
        .rise_en_o (rise_en_w),
        .fall_en_o (fall_en_w),
        .outv_o    (outv_w),
        .mask_o    (mask_w),
        .ien_o     (ien_w),
        .clr_o     (clr_w)
    );

    gpio_irq_unit #(.NPINS(NPINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_w),
        .rise_i    (rise_w),
        .fall_i    (fall_w),
        .lsel_i    (lsel_w),
        .lpol_i    (lpol_w),
        .rise_en_i (rise_en_w),
        .fall_en_i (fall_en_w),
        .clr_i     (clr_w),
        .pend_o    (pend_w)
    );

    assign status_w = pend_w & ~mask_w & ien_w;

    always_comb begin
        irq_d = |status_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pin_out = outv_w;
    assign pin_oe  = dir_w;
    assign irq     = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = REG_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  lsel,
    input logic [NPINS-1:0]  lpol,
    input logic [NPINS-1:0]  sync,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  status
);

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata))); // R2

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OSET)
        |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))
            && ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))); // R4

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OCLR)
        |=> ((pin_out & $past(bus_wdata)) == '0)
            && ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata)))); // R4

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(lsel)) == ($past(sync ~^ lpol) & $past(lsel)))); // R6

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_ICLR)
        |=> (($past(pend) & ~$past(lsel) & ~pend) == '0)); // R7

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> irq); // R10

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq); // R10

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .lsel      (lsel_w),
    .lpol      (lpol_w),
    .sync      (sync_w),
    .pend      (pend_w),
    .status    (status_w)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] bus_rdata, pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Behavioural reference model
    logic [15:0] m_dir = '0, m_lsel = '0, m_lpol = '0, m_rise = '0, m_fall = '0;
    logic [15:0] m_out = '0, m_mask = 16'hFFFF, m_ien = '0, m_pend = '0, m_rdata = '0;
    logic [15:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic        m_irq = 1'b0;

    always @(posedge clk) begin : model
        logic [15:0] stat;
        logic        hit;
        if (!rst_n) begin
            m_dir = '0; m_lsel = '0; m_lpol = '0; m_rise = '0; m_fall = '0;
            m_out = '0; m_mask = 16'hFFFF; m_ien = '0; m_pend = '0; m_rdata = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 1'b0;
        end else begin
            stat = m_pend & ~m_mask & m_ien;
            if (bus_rd) begin
                case (bus_addr)
                    8'h00:   m_rdata = m_dir;
                    8'h04:   m_rdata = m_lsel;
                    8'h08:   m_rdata = m_lpol;
                    8'h0C:   m_rdata = m_rise;
                    8'h10:   m_rdata = m_fall;
                    8'h14:   m_rdata = m_s2;
                    8'h20:   m_rdata = m_out;
                    8'h28:   m_rdata = m_mask;
                    8'h2C:   m_rdata = m_ien;
                    8'h30:   m_rdata = stat;
                    default: m_rdata = '0;
                endcase
            end
            for (int i = 0; i < 16; i++) begin
                if (m_lsel[i]) begin
                    m_pend[i] = (m_s2[i] == m_lpol[i]);
                end else begin
                    hit = (m_rise[i] && m_s2[i] && !m_prev[i]) ||
                          (m_fall[i] && !m_s2[i] && m_prev[i]);
                    if (hit) m_pend[i] = 1'b1;
                    else if (bus_wr && bus_addr == 8'h34 && bus_wdata[i]) m_pend[i] = 1'b0;
                end
            end
            m_irq  = (stat != 0);
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_dir  = bus_wdata;
                    8'h04: m_lsel = bus_wdata;
                    8'h08: m_lpol = bus_wdata;
                    8'h0C: m_rise = bus_wdata;
                    8'h10: m_fall = bus_wdata;
                    8'h18: for (int i = 0; i < 16; i++) if (bus_wdata[i]) m_out[i] = 1'b1;
                    8'h1C: for (int i = 0; i < 16; i++) if (bus_wdata[i]) m_out[i] = 1'b0;
                    8'h20: m_out  = bus_wdata;
                    8'h28: m_mask = bus_wdata;
                    8'h2C: m_ien  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 pin_oe vs model", pin_oe, m_dir);
            check("R3 pin_out vs model", pin_out, m_out);
            check("R10 irq vs model", {15'b0, irq}, {15'b0, m_irq});
            check("R11 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(8'h28, v); check("R1 mask reset", v, 16'hFFFF);
        rd(8'h2C, v); check("R1 enable reset", v, 16'h0000);
        rd(8'h00, v); check("R1 dir reset", v, 16'h0000);
        rd(8'h20, v); check("R1 out reset", v, 16'h0000);
        check("R1 irq reset", {15'b0, irq}, 16'h0000);

        wr(8'h00, 16'h00FF); check("R2 oe", pin_oe, 16'h00FF);
        wr(8'h20, 16'h1234);
        rd(8'h20, v); check("R3 out readback", v, 16'h1234);
        check("R3 pin_out", pin_out, 16'h1234);
        wr(8'h18, 16'h8001); check("R4 set", pin_out, 16'h9235);
        wr(8'h1C, 16'h0204); check("R4 clear", pin_out, 16'h9031);

        pin_in = 16'hA5A5; settle();
        rd(8'h14, v); check("R5 data in", v, 16'hA5A5);

        // edge on pin 0
        wr(8'h2C, 16'h0001); wr(8'h28, 16'hFFFE); wr(8'h0C, 16'h0001);
        pin_in = 16'hA5A4; settle();
        rd(8'h30, v); check("R7 fall ignored", v, 16'h0000);
        pin_in = 16'hA5A5; settle();
        rd(8'h30, v); check("R7 rise pending", v, 16'h0001);
        check("R10 irq high", {15'b0, irq}, 16'h0001);
        settle();
        rd(8'h30, v); check("R7 sticky", v, 16'h0001);
        wr(8'h34, 16'h0001);
        rd(8'h30, v); check("R8 cleared", v, 16'h0000);
        check("R10 irq low", {15'b0, irq}, 16'h0000);

        wr(8'h10, 16'h0001);
        pin_in = 16'hA5A4; settle();
        rd(8'h30, v); check("R7 both: fall", v, 16'h0001);
        wr(8'h34, 16'h0001);
        pin_in = 16'hA5A5; settle();
        rd(8'h30, v); check("R7 both: rise", v, 16'h0001);
        wr(8'h34, 16'h0001);
        rd(8'h30, v); check("R8 cleared again", v, 16'h0000);

        // clear in the cycle the falling edge is evaluated
        pin_in = 16'hA5A4;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(8'h34, 16'h0001);
        rd(8'h30, v); check("R8 edge wins", v, 16'h0001);
        wr(8'h34, 16'h0001);
        rd(8'h30, v); check("R8 later clear", v, 16'h0000);

        // gating on pin 1
        wr(8'h0C, 16'h0003); wr(8'h2C, 16'h0003);
        pin_in = 16'hA5A6; settle();
        rd(8'h30, v); check("R9 masked", v, 16'h0000);
        check("R9 masked irq", {15'b0, irq}, 16'h0000);
        wr(8'h28, 16'hFFFC);
        rd(8'h30, v); check("R9 unmasked", v, 16'h0002);
        wr(8'h2C, 16'h0001);
        rd(8'h30, v); check("R9 disabled", v, 16'h0000);
        wr(8'h2C, 16'h0003); wr(8'h34, 16'h0002);

        // level on pin 2, active low
        wr(8'h2C, 16'h0007); wr(8'h28, 16'hFFF8); wr(8'h04, 16'h0004);
        settle();
        rd(8'h30, v); check("R6 inactive", v, 16'h0000);
        pin_in = 16'hA5A2; settle();
        rd(8'h30, v); check("R6 active low", v, 16'h0004);
        wr(8'h34, 16'h0004); @(negedge clk);
        rd(8'h30, v); check("R6 clear blocked", v, 16'h0004);
        wr(8'h08, 16'h0004); @(negedge clk);
        rd(8'h30, v); check("R6 polarity high", v, 16'h0000);

        rd(8'h24, v); check("R11 unmapped", v, 16'h0000);
        rd(8'h18, v); check("R11 set reads 0", v, 16'h0000);
        wr(8'h14, 16'hFFFF);
        rd(8'h14, v); check("R11 din write ignored", v, 16'hA5A2);
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule